// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from 4-bit stages that chain through a look-ahead carry. Each stage has an asynchronous active-low clear, a synchronous active-low parallel load and two count enables. One enable is broadcast to every stage. The other one, the carry enable, also gates the stage's terminal-count output, and that output drives the carry enable of the next stage up. Put together, the stages act as one wide binary counter.

The top module holds `STAGES` stages. The bottom stage's carry enable is brought out as a port. A standalone counter ties that port high. When it is left as a port, the whole chain can be cascaded again behind another counter. Load takes priority over counting and is not affected by either enable. Clear takes priority over everything else and does not wait for the clock.

Top module: `casc_counter`

## Requirements
- R1: While `clr_n` is low, `count` is zero at once, without a clock edge, whatever the other inputs are. This includes a clock edge that arrives with `load_n` low.
- R2: While `clr_n` is low, `term` is low.
- R3: With `clr_n` high and `load_n` low at a rising clock edge, `count` takes `load_val`, whatever the levels of `en_par` and `en_carry`.
- R4: With `clr_n` and `load_n` high and both `en_par` and `en_carry` high at a rising edge, `count` goes up by one.
- R5: With `clr_n` and `load_n` high and either enable low at a rising edge, `count` keeps its value.
- R6: `term` is high exactly when `en_carry` is high and `count` is all ones. A change on `en_carry` reaches `term` without a clock edge.
- R7: Counting from all ones gives zero, so the counter passes through every binary state in order.
- R8: Stage k (k > 0) takes its carry enable from the terminal count of stage k-1. `en_par` goes to every stage. A carry out of a low nibble therefore increments the nibble above it only when the counter counts, and never when only `en_carry` is high.
- R9: Starting from clear, a load of 0xFC followed by counting gives FD, FE, FF, 00, 01, 02. Dropping either enable then holds 02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load strobe, active low |
| load_val | input | STAGES*4 | Value copied into the counter on a load |
| en_par | input | 1 | Count enable broadcast to all stages |
| en_carry | input | 1 | Carry enable of the bottom stage, also gates `term` |
| count | output | STAGES*4 | Counter value |
| term | output | 1 | Terminal count of the top stage |

## Verification
The counting function is driven with four kinds of pattern:
- Pure count runs across nibble and full-width wraps, which separate a correct carry chain from one that increments the wrong stage.
- Enables dropped one at a time, which separate the broadcast enable from the carry enable. The case of the low nibble at 15 with only the carry enable high shows whether the upper stage wrongly follows the terminal count.
- Loads with both enables high, which show whether load is correctly given priority.
- A long pseudo-random mix compared against a bench model after every edge.

Directed cases follow. They check clear mid-cycle and clear over a pending load, and they toggle `en_carry` while the count sits at all ones so that the combinational path to `term` is seen without a clock edge.

// File: rtl/casc_counter_pkg.sv
// Package: shared width and the per-edge action code of a counter stage.
// Assumes: each stage is a 4-bit nibble; wider counters chain stages.
package casc_counter_pkg;

    localparam int NIB_W = 4;

    // Action a stage takes at the next rising edge (clear is asynchronous).
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2
    } stage_act_e;

endpackage

// File: rtl/casc_nib_next.sv
// Module: casc_nib_next
// Purpose: decides the edge action of one stage and forms its next value.
// Assumes: clear is handled in the register itself; load beats counting,
//          counting needs both enables, everything else holds.
module casc_nib_next
    import casc_counter_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] ld_val,
    input  logic         ld_n,
    input  logic         en_p,
    input  logic         en_t,
    output stage_act_e   act,
    output logic [W-1:0] nxt
);

    // Priority decode of the edge action.
    always_comb begin
        if (!ld_n)             act = ACT_LOAD;
        else if (en_p && en_t) act = ACT_COUNT;
        else                   act = ACT_HOLD;
    end

    // Next value for the chosen action; binary add wraps all-ones to zero.
    always_comb begin
        unique case (act)
            ACT_LOAD:  nxt = ld_val;
            ACT_COUNT: nxt = cur + 1'b1;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/casc_nib_stage.sv
// Module: casc_nib_stage
// Purpose: one counter stage with register, asynchronous clear and a
//          terminal-count output gated by the stage's carry enable.
// Assumes: clr_n may change at any time; other inputs are synchronous.
module casc_nib_stage
    import casc_counter_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic [W-1:0] ld_val,
    input  logic         en_p,
    input  logic         en_t,
    output logic [W-1:0] q,
    output logic         tc
);

    localparam logic [W-1:0] ALL_ONES = '1;

    stage_act_e   act;
    logic [W-1:0] q_nxt;

    casc_nib_next #(.W(W)) next_i (
        .cur    (q),
        .ld_val (ld_val),
        .ld_n   (ld_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .act    (act),
        .nxt    (q_nxt)
    );

    // Count register: cleared asynchronously, otherwise updated each edge.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= q_nxt;
    end

    // Terminal count: look-ahead carry out, forced low during clear.
    always_comb begin
        tc = clr_n && en_t && (q == ALL_ONES);
    end

    // R1: clear holds the stage at zero.
    assert_clear_zero_R1: assert property (@(negedge clk)
        !clr_n |-> q == '0);

    // R2: clear keeps the terminal count low.
    assert_clear_tc_R2: assert property (@(negedge clk)
        !clr_n |-> !tc);

    // R3: a load copies the data word regardless of enables.
    assert_load_R3: assert property (@(posedge clk) disable iff (!clr_n)
        !ld_n |=> q == $past(ld_val));

    // R4: both enables high and no load give an increment.
    assert_count_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && en_p && en_t) |=> q == $past(q) + 1'b1);

    // R5: a dropped enable without load keeps the value.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && !(en_p && en_t)) |=> $stable(q));

    // R7: all ones counts to zero.
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && en_p && en_t && q == ALL_ONES) |=> q == '0);

endmodule

// File: rtl/casc_counter.sv
// Module: casc_counter (top)
// Purpose: chains STAGES counter stages into one wide binary counter; each
//          stage's carry enable comes from the terminal count below it.
// Assumes: en_carry is tied high for a standalone counter; en_par and the
//          load strobe are shared by all stages.
module casc_counter
    import casc_counter_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic                    clk,
    input  logic                    clr_n,
    input  logic                    load_n,
    input  logic [STAGES*NIB_W-1:0] load_val,
    input  logic                    en_par,
    input  logic                    en_carry,
    output logic [STAGES*NIB_W-1:0] count,
    output logic                    term
);

    localparam int W = STAGES * NIB_W;

    logic [STAGES:0]   carry;   // carry[k] is the carry enable of stage k
    logic [STAGES-1:0] st_tc;

    // Bottom of the carry chain comes from the port.
    always_comb carry[0] = en_carry;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        casc_nib_stage #(.W(NIB_W)) stage_i (
            .clk    (clk),
            .clr_n  (clr_n),
            .ld_n   (load_n),
            .ld_val (load_val[k*NIB_W +: NIB_W]),
            .en_p   (en_par),
            .en_t   (carry[k]),
            .q      (count[k*NIB_W +: NIB_W]),
            .tc     (st_tc[k])
        );
        // Next stage is enabled by this stage's terminal count.
        always_comb carry[k+1] = st_tc[k];
    end

    // Chain output is the top stage's terminal count.
    always_comb term = carry[STAGES];

    // R6: terminal count implies all ones with carry enable high.
    assert_tc_R6: assert property (@(posedge clk) disable iff (!clr_n)
        term |-> (count == {W{1'b1}}) && en_carry);

    // R8: the chain increments as one wide counter.
    assert_chain_R8: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_carry) |=> count == $past(count) + 1'b1);

    // R8: with the broadcast enable low nothing moves, even at a carry.
    assert_chain_hold_R8: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !en_par) |=> $stable(count));

endmodule

// File: tb/casc_counter_tb_top.sv
module casc_counter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int STG = 2;
    localparam int W = 8;

    typedef struct packed {
        logic         ld_n;
        logic         ep;
        logic         et;
        logic [W-1:0] din;
        logic [W-1:0] exp_q;
        logic         exp_tc;
    } vec_t;

    // Vectors 0..7 form the R9 sequence.
    localparam vec_t VECS [20] = '{
        '{1'b0, 1'b0, 1'b0, 8'hFC, 8'hFC, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFD, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFE, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'h01, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'h02, 1'b0},
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'h02, 1'b0},
        '{1'b1, 1'b1, 1'b0, 8'h00, 8'h02, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'h0E, 8'h0E, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'h0F, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0},
        '{1'b0, 1'b0, 1'b0, 8'h2F, 8'h2F, 1'b0},
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'h2F, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'h30, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'hFE, 8'hFE, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1},
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1},
        '{1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0},
        '{1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}
    };

    logic         clk;
    logic         clr_n;
    logic         load_n;
    logic [W-1:0] load_val;
    logic         en_par;
    logic         en_carry;
    logic [W-1:0] count;
    logic         term;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    casc_counter #(.STAGES(STG)) dut_i (
        .clk      (clk),
        .clr_n    (clr_n),
        .load_n   (load_n),
        .load_val (load_val),
        .en_par   (en_par),
        .en_carry (en_carry),
        .count    (count),
        .term     (term)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Wait for the next rising edge, then let outputs settle.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] model;
        logic [7:0]   lfsr;
        clr_n = 1'b1; load_n = 1'b1; load_val = '0; en_par = 1'b0; en_carry = 1'b0;
        #2 clr_n = 1'b0;
        #1;
        // R1/R2: reset state
        chk("R1 reset count", {1'b0, count}, 9'h000);
        chk("R2 reset term", {8'h00, term}, 9'h000);
        @(negedge clk);
        @(negedge clk);
        clr_n = 1'b1;

        // Vector table: R9 sequence then R3..R8 patterns.
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            load_n = VECS[i].ld_n; en_par = VECS[i].ep; en_carry = VECS[i].et;
            load_val = VECS[i].din;
            tick();
            chk($sformatf("R3-R9 vector %0d count", i), {1'b0, count}, {1'b0, VECS[i].exp_q});
            chk($sformatf("R6 vector %0d term", i), {8'h00, term}, {8'h00, VECS[i].exp_tc});
        end

        // R6: en_carry reaches term with no clock edge while count is FF.
        @(negedge clk);
        load_n = 1'b0; load_val = 8'hFF; en_par = 1'b0; en_carry = 1'b0;
        tick();
        @(negedge clk);
        load_n = 1'b1;
        #1 chk("R6 term low with carry off", {8'h00, term}, 9'h000);
        en_carry = 1'b1;
        #1 chk("R6 term follows carry high", {8'h00, term}, 9'h001);
        en_carry = 1'b0;
        #1 chk("R6 term follows carry low", {8'h00, term}, 9'h000);
        en_carry = 1'b1;
        #1;

        // R1/R2: clear mid-cycle acts without an edge.
        clr_n = 1'b0;
        #1;
        chk("R1 async clear count", {1'b0, count}, 9'h000);
        chk("R2 clear forces term low", {8'h00, term}, 9'h000);
        // R1: clear overrides a pending load across an edge.
        load_n = 1'b0; load_val = 8'hA5; en_par = 1'b1;
        tick();
        chk("R1 clear beats load", {1'b0, count}, 9'h000);
        @(negedge clk);
        load_n = 1'b1; en_par = 1'b0;
        clr_n = 1'b1;
        tick();
        chk("R5 hold after clear", {1'b0, count}, 9'h000);

        // Pseudo-random mix against bench model (R3, R4, R5, R7, R8).
        model = '0;
        lfsr = 8'hB7;
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            load_n   = lfsr[0] | lfsr[1] | lfsr[2];
            en_par   = lfsr[3] | lfsr[4];
            en_carry = lfsr[5] | lfsr[6];
            load_val = {lfsr[3:0], lfsr[7:4]};
            if (!load_n)                model = load_val;
            else if (en_par && en_carry) model = model + 1'b1;
            tick();
            chk("R8 model count", {1'b0, count}, {1'b0, model});
            chk("R6 model term", {8'h00, term}, {8'h00, (en_carry && model == 8'hFF)});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule